// File: doc/BRIEF.md
# Memory-Mapped GPIO Port with Atomic Set/Clear/Toggle Aliases

This block is a general-purpose I/O port of up to 32 lines. It sits on a simple single-cycle register bus with an address, a write enable, write data and combinational read data. It holds three state registers: the output levels, the line directions and the interrupt mask. The pad output values, the pad output enables and the mask come straight from these registers and leave the block as ports. The mask port feeds an interrupt unit that lies outside this block.

Each state register can be loaded directly. It can also be changed through three alias addresses, which OR, AND or XOR the write data into the register in a single bus write. Software can therefore set, clear or toggle single lines without a read-modify-write sequence that another agent could interrupt.

Reads return the pin levels after a two-flop synchronizer, the three state registers, or a read-only capability word. The capability word describes the line count and the interrupt features that the block was built with.

Top module: `gpio_alias_port`

## Requirements
- R1: While reset is asserted, and right after it is released, the output, direction and mask registers are all zero. `pad_out`, `pad_oe` and `irq_mask` therefore read zero.
- R2: A write to offset 0x04, 0x08 or 0x0C loads the write data into the output, direction or mask register. The change is visible after the clock edge that takes the write, and a read at the same offset returns it.
- R3: A write to 0x54, 0x58 or 0x5C ORs the write data into the output, direction or mask register. Set bits become 1 and all other bits keep their value.
- R4: A write to 0x64, 0x68 or 0x6C ANDs the write data into the output, direction or mask register. Bits that are 0 in the write data are cleared and all other bits keep their value.
- R5: A write to 0x74, 0x78 or 0x7C XORs the write data into the output, direction or mask register. Bits that are 1 in the write data are inverted.
- R6: A read at offset 0x00 returns the pin input levels, not the output register. A change on `pin_in` appears there after the second rising clock edge, and not after the first.
- R7: A read at offset 0x1C returns the capability word. It holds the line count minus one in bits 4:0, the interrupt-generation mode in bits 12:8, the interrupt-flag-present bit at 16, the interrupt-enable-present bit at 17 and the pull-up-support bit at 18. All other bits are 0. With the default parameters the word is 0x00030117.
- R8: All other offsets, the alias offsets included, read as zero. A write to any offset other than the twelve writable ones changes no register; this includes the data offset and the capability offset.
- R9: Register and data bits at or above the configured line count (24 by default) read as zero, and write data in those bits is ignored.
- R10: For each line, `pad_oe` equals its direction bit (1 = drive, 0 = input), `pad_out` equals its output register bit and `irq_mask` equals its mask bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 7 | Byte address of the register access |
| bus_we | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pin_in | input | NLINES | Raw pin input levels |
| pad_out | output | NLINES | Pad output values |
| pad_oe | output | NLINES | Pad output enables |
| irq_mask | output | NLINES | Interrupt mask sent to the interrupt unit |

## Verification
A corrupted output, direction or mask bit shows at once on `pad_out`, `pad_oe` or `irq_mask`, one edge after the write that caused it. The bench compares those ports after every write. A wrong alias operation, such as OR decoded as XOR, only differs from the correct result when the register already holds particular bit values. The random writes therefore run on top of accumulated state, and the register is read back after each write. A synchronizer with the wrong depth shows in the cycle after a pin change, so the data offset is read after both the first and the second edge.

// File: rtl/gpio_pkg.sv
package gpio_pkg;

    // Kind of update a write applies to a state register.
    typedef enum logic [1:0] {
        OP_LOAD = 2'd0,
        OP_OR   = 2'd1,
        OP_AND  = 2'd2,
        OP_XOR  = 2'd3
    } alias_op_e;

    // Register index carried in address bits 3:2.
    localparam int unsigned IDX_OUT  = 1;
    localparam int unsigned IDX_DIR  = 2;
    localparam int unsigned IDX_MASK = 3;
    localparam int unsigned NREGS    = 3;

    // Address groups in bits 6:4.
    localparam logic [2:0] GRP_DIRECT = 3'h0;
    localparam logic [2:0] GRP_CAP    = 3'h1;
    localparam logic [2:0] GRP_OR     = 3'h5;
    localparam logic [2:0] GRP_AND    = 3'h6;
    localparam logic [2:0] GRP_XOR    = 3'h7;

endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int unsigned WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] async_in,
    output logic [WIDTH-1:0] sync_out
);
    typedef struct packed {
        logic [WIDTH-1:0] meta;
        logic [WIDTH-1:0] stable;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d.meta   = async_in;
        st_d.stable = st_q.meta;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sync_out = st_q.stable;

endmodule

// File: rtl/gpio_decode.sv
module gpio_decode
    import gpio_pkg::*;
#(
    parameter int unsigned ADDR_W = 7
) (
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    output logic [NREGS-1:0]  wr_sel,
    output alias_op_e         wr_op
);
    logic [2:0] grp;
    logic [1:0] idx;

    assign grp = addr[6:4];
    assign idx = addr[3:2];

    always_comb begin
        wr_sel = '0;
        wr_op  = OP_LOAD;
        unique case (grp)
            GRP_DIRECT: wr_op = OP_LOAD;
            GRP_OR:     wr_op = OP_OR;
            GRP_AND:    wr_op = OP_AND;
            GRP_XOR:    wr_op = OP_XOR;
            default:    wr_op = OP_LOAD;
        endcase
        if (we && idx != 2'd0 &&
            (grp == GRP_DIRECT || grp == GRP_OR || grp == GRP_AND || grp == GRP_XOR)) begin
            wr_sel[idx - 2'd1] = 1'b1;
        end
    end

endmodule

// File: rtl/gpio_alias_reg.sv
module gpio_alias_reg
    import gpio_pkg::*;
#(
    parameter int unsigned WIDTH = 24
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  alias_op_e        wr_op,
    input  logic [WIDTH-1:0] wr_data,
    output logic [WIDTH-1:0] value
);
    logic [WIDTH-1:0] val_d, val_q;

    always_comb begin
        val_d = val_q;
        if (wr_en) begin
            unique case (wr_op)
                OP_LOAD: val_d = wr_data;
                OP_OR:   val_d = val_q | wr_data;
                OP_AND:  val_d = val_q & wr_data;
                OP_XOR:  val_d = val_q ^ wr_data;
                default: val_d = val_q;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) val_q <= '0;
        else        val_q <= val_d;
    end

    assign value = val_q;

    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == OP_LOAD) |=> value == $past(wr_data)); // R2
    AST_OR_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == OP_OR) |=> (value & $past(wr_data)) == $past(wr_data)
            && (value & ~$past(wr_data)) == ($past(value) & ~$past(wr_data))); // R3
    AST_AND_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == OP_AND) |=> (value & ~$past(wr_data)) == '0
            && (value & $past(wr_data)) == ($past(value) & $past(wr_data))); // R4
    AST_XOR_FLIPS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_op == OP_XOR) |=> (value ^ $past(value)) == $past(wr_data)); // R5
    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(value)); // R8

endmodule

// File: rtl/gpio_alias_port.sv
module gpio_alias_port
    import gpio_pkg::*;
#(
    parameter int unsigned NLINES     = 24,
    parameter int unsigned ADDR_W     = 7,
    parameter logic [4:0]  IRQ_MODE   = 5'd1,
    parameter bit          HAS_IFLAG  = 1'b1,
    parameter bit          HAS_IEN    = 1'b1,
    parameter bit          HAS_PULLUP = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_we,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    input  logic [NLINES-1:0] pin_in,
    output logic [NLINES-1:0] pad_out,
    output logic [NLINES-1:0] pad_oe,
    output logic [NLINES-1:0] irq_mask
);
    localparam logic [4:0] LAST_LINE = 5'(NLINES - 1);
    localparam logic [31:0] CAP_WORD = {13'd0, HAS_PULLUP, HAS_IEN, HAS_IFLAG,
                                        3'd0, IRQ_MODE, 3'd0, LAST_LINE};

    logic [NREGS-1:0]  wr_sel;
    alias_op_e         wr_op;
    logic [NLINES-1:0] reg_val [NREGS];
    logic [NLINES-1:0] pin_sync;

    gpio_decode #(.ADDR_W(ADDR_W)) u_dec (
        .we     (bus_we),
        .addr   (bus_addr),
        .wr_sel (wr_sel),
        .wr_op  (wr_op)
    );

    for (genvar g = 0; g < NREGS; g++) begin : g_reg
        gpio_alias_reg #(.WIDTH(NLINES)) u_reg (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (wr_sel[g]),
            .wr_op   (wr_op),
            .wr_data (bus_wdata[NLINES-1:0]),
            .value   (reg_val[g])
        );
    end

    gpio_sync #(.WIDTH(NLINES)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pin_in),
        .sync_out (pin_sync)
    );

    assign pad_out  = reg_val[IDX_OUT-1];
    assign pad_oe   = reg_val[IDX_DIR-1];
    assign irq_mask = reg_val[IDX_MASK-1];

    always_comb begin
        bus_rdata = '0;
        if (bus_addr[6:4] == GRP_DIRECT) begin
            unique case (bus_addr[3:2])
                2'd0:    bus_rdata[NLINES-1:0] = pin_sync;
                2'd1:    bus_rdata[NLINES-1:0] = pad_out;
                2'd2:    bus_rdata[NLINES-1:0] = pad_oe;
                default: bus_rdata[NLINES-1:0] = irq_mask;
            endcase
        end else if (bus_addr[6:2] == 5'h07) begin
            bus_rdata = CAP_WORD;
        end
    end

    AST_RESERVED_WRITE_INERT: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr[3:2] == 2'd0) |=>
            $stable(pad_out) && $stable(pad_oe) && $stable(irq_mask)); // R8
    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({$changed(pad_out), $changed(pad_oe), $changed(irq_mask)})); // R10
    AST_CAP_FIXED: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_addr == 7'h1C) |-> bus_rdata == CAP_WORD); // R7

endmodule

// File: tb/tb_gpio_alias_port.sv
`timescale 1ns/1ps
module tb_gpio_alias_port;
    localparam int N = 24;
    localparam logic [31:0] LMASK = 32'h00FF_FFFF;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [N-1:0] pin_in = '0;
    logic [N-1:0] pad_out, pad_oe, irq_mask;

    int checks = 0;
    int errors = 0;
    logic [31:0] m_reg [3];
    int unsigned seed = 32'h1234_5678;

    always #2 clk = ~clk;

    gpio_alias_port dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_we(bus_we),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pad_out(pad_out), .pad_oe(pad_oe), .irq_mask(irq_mask)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: got %08h expected %08h", tag, act, exp);
        end
    endtask

    function automatic logic [31:0] apply(input logic [31:0] cur, input logic [2:0] grp,
                                          input logic [31:0] d);
        case (grp)
            3'h0: return d & LMASK;
            3'h5: return (cur | d) & LMASK;
            3'h6: return cur & d & LMASK;
            3'h7: return (cur ^ d) & LMASK;
            default: return cur;
        endcase
    endfunction

    task automatic wr(input logic [6:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_we = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_we = 1'b0;
        if (a[3:2] != 2'd0 && (a[6:4] == 3'h0 || a[6:4] >= 3'h5))
            m_reg[a[3:2]-1] = apply(m_reg[a[3:2]-1], a[6:4], d);
    endtask

    task automatic rd(input string tag, input logic [6:0] a, input logic [31:0] exp);
        bus_addr = a; bus_we = 1'b0;
        #0.5;
        check(tag, bus_rdata, exp);
    endtask

    task automatic check_pads(input string tag);
        check({tag, " R10 pad_out"}, {8'd0, pad_out}, m_reg[0]);
        check({tag, " R10 pad_oe"},  {8'd0, pad_oe},  m_reg[1]);
        check({tag, " R10 irq_mask"}, {8'd0, irq_mask}, m_reg[2]);
    endtask

    initial begin
        #(4 * 150000);
        errors++; checks++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        for (int i = 0; i < 3; i++) m_reg[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        check("R1 pad_out in reset", {8'd0, pad_out}, 0);
        check("R1 pad_oe in reset", {8'd0, pad_oe}, 0);
        @(negedge clk); rst_n = 1'b1;
        @(negedge clk);
        check("R1 irq_mask after reset", {8'd0, irq_mask}, 0);
        rd("R1 out read", 7'h04, 0);

        // Direct loads, upper bits ignored (R2, R9)
        wr(7'h04, 32'hFFA5_5A3C); rd("R2 R9 out load", 7'h04, m_reg[0]);
        wr(7'h08, 32'h0F0F_0F0F); rd("R2 dir load", 7'h08, m_reg[1]);
        wr(7'h0C, 32'h1234_5678); rd("R2 mask load", 7'h0C, m_reg[2]);
        check_pads("R2");
        check("R9 upper bits", m_reg[0] & ~LMASK, 0);

        // Directed alias cases
        wr(7'h04, 32'h0000_00F0);
        wr(7'h54, 32'h0000_0F00); rd("R3 out or", 7'h04, 32'h0000_0FF0);
        wr(7'h64, ~32'h0000_0030); rd("R4 out and", 7'h04, 32'h0000_0FC0);
        wr(7'h74, 32'h0000_00FF); rd("R5 out xor", 7'h04, 32'h0000_0F3F);
        wr(7'h58, 32'h0080_0000); rd("R3 dir or top line", 7'h08, m_reg[1]);
        wr(7'h68, 32'h0); rd("R4 dir and clear all", 7'h08, 0);
        wr(7'h7C, 32'hFFFF_FFFF); rd("R5 R9 mask xor all", 7'h0C, m_reg[2]);
        check_pads("R3 R4 R5");

        // Ignored writes and zero reads (R8)
        wr(7'h00, 32'hFFFF_FFFF); wr(7'h1C, 32'hFFFF_FFFF);
        wr(7'h50, 32'hFFFF_FFFF); wr(7'h60, 32'h0); wr(7'h30, 32'hFFFF_FFFF);
        wr(7'h44, 32'hFFFF_FFFF); wr(7'h24, 32'h0);
        check_pads("R8 after ignored writes");
        rd("R8 reserved 0x30", 7'h30, 0);
        rd("R8 alias read 0x54", 7'h54, 0);
        rd("R8 alias read 0x78", 7'h78, 0);
        rd("R8 reserved 0x40", 7'h40, 0);

        // Capability word (R7)
        rd("R7 cap word", 7'h1C, 32'h0003_0117);

        // Synchronizer depth (R6)
        @(negedge clk); pin_in = 24'hA5C3E1;
        @(posedge clk); #1; rd("R6 not after one edge", 7'h00, 0);
        @(posedge clk); #1; rd("R6 after two edges", 7'h00, 32'h00A5_C3E1);
        @(negedge clk); pin_in = 24'h3C3C3C;
        @(posedge clk); @(posedge clk); #1;
        rd("R6 data not output reg", 7'h00, 32'h003C_3C3C);

        // Random mix of all writable offsets
        void'($urandom(seed));
        for (int it = 0; it < 400; it++) begin
            logic [6:0] a;
            logic [2:0] g;
            logic [1:0] ix;
            logic [31:0] d;
            int k;
            k = $urandom_range(0, 4);
            g = (k == 0) ? 3'h0 : (k == 4) ? 3'($urandom_range(1, 4)) : 3'(4 + k);
            ix = 2'($urandom_range(0, 3));
            a = {g, ix, 2'b00};
            d = $urandom;
            wr(a, d);
            if (ix != 0) rd("R2 R3 R4 R5 random readback", {3'h0, ix, 2'b00}, m_reg[ix-1]);
            if (it % 8 == 0) check_pads("R10 random");
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule